// File: doc/BRIEF.md
# Two-Level Sticky Interrupt Controller

This block gathers fifteen active-high interrupt request lines from peripherals and reports one interrupt number to a single processor. A request line that is high at a clock edge sets a sticky pending bit. The bit stays set until software clears it or the processor acknowledges that number. A per-line enable mask decides which pending lines may compete. A per-line level bit places each line in one of two priority classes. The registered output carries the number of the winning line, or zero when no enabled line is pending.

Software reaches the registers as an APB slave with zero wait states. It can program the enables and the levels, read the pending set, force pending bits for test, and clear pending bits with write-1-to-clear semantics. The processor side has a valid strobe and a 4-bit number. The strobe clears the pending bit of the line it names.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: Lines are numbered 1 to 15 and the output number 0 means no interrupt. Bit 0 of every register reads 0, and a write to bit 0 has no effect.
- R2: A request line that is high at a rising clock edge has its pending bit (bit n for line n) set from that edge on.
- R3: A pending bit stays set after its request line falls. It clears only through a software clear or a processor acknowledge.
- R4: At an edge where ackValid is high and ackNum is n (1 to 15), pending bit n is cleared. An ackNum of 0 changes nothing.
- R5: A write of data to byte offset 0x0C clears each pending bit where the data holds a 1. A request high in the same cycle wins, and the bit stays set.
- R6: A write of data to byte offset 0x08 sets each pending bit where the data holds a 1.
- R7: The enable register at byte offset 0x40 admits line n when bit n is 1. A line that is pending but not enabled never appears on irqLevel and stays pending.
- R8: The level register at byte offset 0x00 puts line n in the high class when bit n is 1. Any enabled pending high-class line beats every low-class line. Inside a class, the higher line number wins.
- R9: irqLevel is registered. It shows the winner for the pending, enable and level state of the previous cycle, so a change appears exactly one cycle later.
- R10: Reads return the level register at 0x00, the pending set at 0x04 and the enable register at 0x40. All other offsets read 0, and pReady is always 1. After reset, the pending, enable and level registers and irqLevel are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pSel | input | 1 | APB select |
| pEnable | input | 1 | APB access phase |
| pWrite | input | 1 | APB write when high |
| pAddr | input | 8 | APB byte address |
| pWdata | input | 32 | APB write data |
| pRdata | output | 32 | APB read data |
| pReady | output | 1 | APB ready, tied high |
| irqIn | input | 15 | Request lines, bit n is line n |
| ackValid | input | 1 | Processor acknowledge strobe |
| ackNum | input | 4 | Number of the acknowledged line |
| irqLevel | output | 4 | Winning line number, 0 for none |

## Verification
The bench targets a request colliding with a software clear on the same line. A design that let the clear win would silently drop an interrupt. It also checks a high-class line of low number against a low-class line of high number. Getting the class order wrong would serve the wrong line first. An acknowledge of number 0, and a force write with bit 0 set, must leave the pending set unchanged. Latency is checked every cycle against a bench model, so an output that is combinational or two cycles late is reported at once.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;

  localparam logic [7:0] OFS_LEVEL = 8'h00;
  localparam logic [7:0] OFS_PEND  = 8'h04;
  localparam logic [7:0] OFS_FORCE = 8'h08;
  localparam logic [7:0] OFS_CLEAR = 8'h0C;
  localparam logic [7:0] OFS_MASK  = 8'h40;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_LEVEL = 2'd1,
    RD_PEND  = 2'd2,
    RD_MASK  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrLevel;
    logic   wrForce;
    logic   wrClear;
    logic   wrMask;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irq_sticky_regctl.sv
module irq_sticky_regctl
  import irq_sticky_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  output regStrobe_t        strb
);

  logic       wrAccess;
  logic [7:0] byteOfs;

  assign wrAccess = pSel && pEnable && pWrite;
  assign byteOfs  = 8'(pAddr);

  always_comb begin
    strb         = '0;
    strb.wrLevel = wrAccess && (byteOfs == OFS_LEVEL);
    strb.wrForce = wrAccess && (byteOfs == OFS_FORCE);
    strb.wrClear = wrAccess && (byteOfs == OFS_CLEAR);
    strb.wrMask  = wrAccess && (byteOfs == OFS_MASK);
    strb.rdSel   = RD_NONE;
    if (pSel && !pWrite) begin
      unique case (byteOfs)
        OFS_LEVEL: strb.rdSel = RD_LEVEL;
        OFS_PEND:  strb.rdSel = RD_PEND;
        OFS_MASK:  strb.rdSel = RD_MASK;
        default:   strb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_sticky_datapath.sv
module irq_sticky_datapath
  import irq_sticky_pkg::*;
#(
  parameter int NUM_LINES = 15,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [DATA_W-1:0]    pWdata,
  input  logic [NUM_LINES:1]   irqIn,
  input  logic                 ackValid,
  input  logic [ID_W-1:0]      ackNum,
  output logic [DATA_W-1:0]    pRdata,
  output logic [ID_W-1:0]      irqLevel,
  output logic [NUM_LINES:0]   pendVec,
  output logic [NUM_LINES:0]   maskVec
);

  localparam int VEC_W = NUM_LINES + 1;

  logic [NUM_LINES:0] levelVec;
  logic [NUM_LINES:0] wrBits;
  logic [NUM_LINES:0] reqBits;
  logic [NUM_LINES:0] ackBits;
  logic [NUM_LINES:0] pendNext;
  logic [NUM_LINES:0] liveVec;
  logic [ID_W-1:0]    hiId;
  logic [ID_W-1:0]    loId;
  logic [ID_W-1:0]    winId;

  assign wrBits  = {pWdata[NUM_LINES:1], 1'b0};
  assign reqBits = {irqIn, 1'b0};

  assign ackBits[0] = 1'b0;
  for (genvar g = 1; g <= NUM_LINES; g++) begin : g_ack
    assign ackBits[g] = ackValid && (ackNum == ID_W'(g));
  end

  always_comb begin
    pendNext = pendVec;
    if (strb.wrClear) pendNext = pendNext & ~wrBits;
    pendNext = pendNext & ~ackBits;
    pendNext = pendNext | reqBits;
    if (strb.wrForce) pendNext = pendNext | wrBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVec  <= '0;
      maskVec  <= '0;
      levelVec <= '0;
    end else begin
      pendVec <= pendNext;
      if (strb.wrMask)  maskVec  <= wrBits;
      if (strb.wrLevel) levelVec <= wrBits;
    end
  end

  assign liveVec = pendVec & maskVec;

  always_comb begin
    hiId = '0;
    loId = '0;
    for (int i = 1; i <= NUM_LINES; i++) begin
      if (liveVec[i] && levelVec[i])  hiId = ID_W'(i);
      if (liveVec[i] && !levelVec[i]) loId = ID_W'(i);
    end
    winId = (hiId != '0) ? hiId : loId;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLevel <= '0;
    else       irqLevel <= winId;
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_LEVEL: pRdata = DATA_W'(levelVec);
      RD_PEND:  pRdata = DATA_W'(pendVec);
      RD_MASK:  pRdata = DATA_W'(maskVec);
      default:  pRdata = '0;
    endcase
  end

  logic unusedVec;
  assign unusedVec = ^{VEC_W[0], pWdata[0]};

endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import irq_sticky_pkg::*;
#(
  parameter int NUM_LINES = 15,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pSel,
  input  logic                 pEnable,
  input  logic                 pWrite,
  input  logic [ADDR_W-1:0]    pAddr,
  input  logic [DATA_W-1:0]    pWdata,
  output logic [DATA_W-1:0]    pRdata,
  output logic                 pReady,
  input  logic [NUM_LINES:1]   irqIn,
  input  logic                 ackValid,
  input  logic [ID_W-1:0]      ackNum,
  output logic [ID_W-1:0]      irqLevel
);

  regStrobe_t         strb;
  logic [NUM_LINES:0] pendVec;
  logic [NUM_LINES:0] maskVec;

  assign pReady = 1'b1;

  irq_sticky_regctl #(.ADDR_W(ADDR_W)) u_regctl (
    .pSel    (pSel),
    .pEnable (pEnable),
    .pWrite  (pWrite),
    .pAddr   (pAddr),
    .strb    (strb)
  );

  irq_sticky_datapath #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ID_W      (ID_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pWdata   (pWdata),
    .irqIn    (irqIn),
    .ackValid (ackValid),
    .ackNum   (ackNum),
    .pRdata   (pRdata),
    .irqLevel (irqLevel),
    .pendVec  (pendVec),
    .maskVec  (maskVec)
  );

endmodule

// File: rtl/irq_sticky_chk.sv
module irq_sticky_chk #(
  parameter int NUM_LINES = 15,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pSel,
  input logic                 pEnable,
  input logic                 pWrite,
  input logic [ADDR_W-1:0]    pAddr,
  input logic [DATA_W-1:0]    pWdata,
  input logic [DATA_W-1:0]    pRdata,
  input logic [NUM_LINES:1]   irqIn,
  input logic                 ackValid,
  input logic [ID_W-1:0]      ackNum,
  input logic [ID_W-1:0]      irqLevel,
  input logic [NUM_LINES:0]   pendVec,
  input logic [NUM_LINES:0]   maskVec
);

  logic [NUM_LINES:0] dropVec;
  logic [NUM_LINES:0] reqVec;
  logic               swClr;

  assign swClr  = pSel && pEnable && pWrite && (8'(pAddr) == 8'h0C);
  assign reqVec = {irqIn, 1'b0};

  always_comb begin
    dropVec = swClr ? pWdata[NUM_LINES:0] : '0;
    for (int i = 1; i <= NUM_LINES; i++) begin
      if (ackValid && ackNum == ID_W'(i)) dropVec[i] = 1'b1;
    end
  end

  // R2
  req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendVec & $past(reqVec)) == $past(reqVec)));

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendVec & $past(pendVec & ~dropVec)) == $past(pendVec & ~dropVec)));

  // R1
  bit_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[0] == 1'b0) && (pRdata[0] == 1'b0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & maskVec) == '0) |=> (irqLevel == '0));

  // R9
  live_reported_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & maskVec) != '0) |=> (irqLevel != '0));

endmodule

bind irq_sticky_ctrl irq_sticky_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .ID_W      (ID_W)
) u_chk (.*);

// File: tb/irq_sticky_ctrl_tb.sv
module irq_sticky_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        pReady;
  logic [15:1] irqIn = '0;
  logic        ackValid = 1'b0;
  logic [3:0]  ackNum = '0;
  logic [3:0]  irqLevel;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cycChk = 0;

  logic [15:0] mPend, mMask, mLvl, nxt;
  logic [3:0]  expIrq;

  always #5 clk = ~clk;

  irq_sticky_ctrl u_dut (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .irqIn(irqIn), .ackValid(ackValid), .ackNum(ackNum), .irqLevel(irqLevel)
  );

  function automatic logic [3:0] pick(logic [15:0] p, logic [15:0] m, logic [15:0] l);
    logic [15:0] e;
    logic [3:0]  hi, lo;
    e = p & m & 16'hFFFE;
    hi = 0; lo = 0;
    for (int i = 1; i < 16; i++) begin
      if (e[i] && l[i])  hi = 4'(i);
      if (e[i] && !l[i]) lo = 4'(i);
    end
    return (hi != 0) ? hi : lo;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend <= 0; mMask <= 0; mLvl <= 0; expIrq <= 0;
    end else begin
      expIrq <= pick(mPend, mMask, mLvl);
      nxt = mPend;
      if (pSel && pEnable && pWrite && pAddr == 8'h0C) nxt = nxt & ~pWdata[15:0];
      if (ackValid && ackNum != 0) nxt[ackNum] = 1'b0;
      nxt = nxt | {irqIn, 1'b0};
      if (pSel && pEnable && pWrite && pAddr == 8'h08) nxt = nxt | pWdata[15:0];
      nxt[0] = 1'b0;
      mPend <= nxt;
      if (pSel && pEnable && pWrite && pAddr == 8'h00) mLvl  <= pWdata[15:0] & 16'hFFFE;
      if (pSel && pEnable && pWrite && pAddr == 8'h40) mMask <= pWdata[15:0] & 16'hFFFE;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cycChk && !done) chk("R9 R8 irqLevel per cycle", 32'(irqLevel), 32'(expIrq));
  end

  task automatic apbWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); pSel = 1; pEnable = 0; pWrite = 1; pAddr = a; pWdata = d;
    @(negedge clk); pEnable = 1;
    @(negedge clk); pSel = 0; pEnable = 0; pWrite = 0;
  endtask

  task automatic apbRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); pSel = 1; pEnable = 0; pWrite = 0; pAddr = a;
    @(negedge clk); pEnable = 1;
    #1 d = pRdata;
    @(negedge clk); pSel = 0; pEnable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: reset state
    chk("R10 reset irqLevel", 32'(irqLevel), 0);
    chk("R10 pReady high", 32'(pReady), 1);
    apbRead(8'h04, rd); chk("R10 reset pending", rd, 0);
    apbRead(8'h40, rd); chk("R10 reset enable", rd, 0);
    apbRead(8'h00, rd); chk("R10 reset level", rd, 0);
    cycChk = 1;

    // R2 R3 R7: one-cycle pulse on line 5 while disabled
    @(negedge clk); irqIn = 15'(1 << 4);
    @(negedge clk); irqIn = 0;
    idle(2);
    chk("R7 disabled line silent", 32'(irqLevel), 0);
    apbRead(8'h04, rd); chk("R2 R3 pulse latched sticky", rd, 32'h20);
    apbWrite(8'h40, 32'hFFFF);
    apbRead(8'h40, rd); chk("R1 enable bit0 ignored", rd, 32'hFFFE);
    chk("R7 enabled line reported", 32'(irqLevel), 5);

    // R8: classes and number order
    apbWrite(8'h08, 32'h0208);            // lines 3 and 9
    idle(2);
    chk("R8 higher number wins in class", 32'(irqLevel), 9);
    apbWrite(8'h00, 32'h0008);            // line 3 high class
    idle(1);
    chk("R8 high class beats number", 32'(irqLevel), 3);

    // R4: acknowledge
    @(negedge clk); ackValid = 1; ackNum = 3;
    @(negedge clk); ackValid = 1; ackNum = 0;
    @(negedge clk); ackValid = 0;
    idle(1);
    chk("R4 ack cleared line 3", 32'(irqLevel), 9);
    apbRead(8'h04, rd); chk("R4 ack 0 no effect", rd, 32'h220);

    // R5: request beats software clear
    @(negedge clk); irqIn = 15'(1 << 8);
    apbWrite(8'h0C, 32'h0220);
    irqIn = 0;
    apbRead(8'h04, rd); chk("R5 request wins over clear", rd, 32'h200);
    apbWrite(8'h0C, 32'h0200);
    apbRead(8'h04, rd); chk("R5 clear alone empties", rd, 0);
    chk("R9 no pending gives 0", 32'(irqLevel), 0);

    // R6 R1: force with bit 0
    apbWrite(8'h08, 32'hFFFF_FFFF);
    apbRead(8'h04, rd); chk("R6 R1 force all lines", rd, 32'hFFFE);
    apbRead(8'h10, rd); chk("R10 unmapped reads 0", rd, 0);
    apbRead(8'h08, rd); chk("R10 force offset reads 0", rd, 0);
    apbWrite(8'h0C, 32'hFFFF);

    // random mix
    for (int it = 0; it < 600; it++) begin
      @(negedge clk);
      irqIn    = 15'($urandom & $urandom & $urandom);
      ackValid = ($urandom % 3) == 0;
      ackNum   = 4'($urandom);
      if (($urandom % 6) == 0) begin
        case ($urandom % 5)
          0: apbWrite(8'h00, $urandom);
          1: apbWrite(8'h08, $urandom & $urandom);
          2: apbWrite(8'h0C, $urandom);
          3: apbWrite(8'h40, $urandom);
          default: begin
            apbRead(8'h04, rd);
            chk("R2 R3 random pending", rd, 32'(mPend));
          end
        endcase
      end
    end
    @(negedge clk); irqIn = 0; ackValid = 0;
    idle(2);
    apbRead(8'h40, rd); chk("R7 random enable readback", rd, 32'(mMask));
    apbRead(8'h00, rd); chk("R8 random level readback", rd, 32'(mLvl));
    finishRun();
  end

endmodule